// File: doc/BRIEF.md
# DDS Phase Accumulator Core

This block is the numeric heart of a direct digital synthesizer. On every reference clock edge it adds a 32-bit tuning word to a 32-bit phase register, so the register wraps at a rate of tuning_word × f_clk / 2^32. The output frequency therefore has a resolution of f_clk / 2^32 (close to 0.0291 Hz at 125 MHz), and the highest usable frequency is half the reference clock. A 5-bit phase offset rotates the output by any sum of 180°, 90°, 45°, 22.5° and 11.25°. The offset is applied to the phase seen at the outputs only, never to the stored phase.

The offset-adjusted phase is cut down to a 12-bit phase address. That address is published as a phase word and drives three things: a square wave, taken from its top bit; a quadrant-folded quarter-wave sine table; and a registered signed 10-bit sample. A power-down input freezes the phase register and forces the sample to mid-scale zero. Loading the tuning and control words, the DAC and the analog output path all sit outside this block.

Top module: `dds_nco_core`

## Requirements
- R1: While power-down is low, each rising clock edge adds the tuning word to the 32-bit phase register modulo 2^32, so after n edges from reset with a constant word W the register holds n×W mod 2^32.
- R2: `phase_o` equals the top 12 bits of (phase register + offset_register × 2^27), taken modulo 2^12. The offset register loads `ofs_i` on every clock edge. Offset bit 4 moves the phase address by 0x800 (180°), bit 3 by 0x400, bit 2 by 0x200, bit 1 by 0x100 and bit 0 by 0x080 (11.25°).
- R3: The offset never changes the phase register. When the offset returns to zero, `phase_o` is back on the trajectory it would have followed with no offset.
- R4: `square_o` equals bit 11 of `phase_o`.
- R5: `sample_o` is registered. After each edge it holds the sine value for the `phase_o` seen before that edge. The quarter table is T[k] = round(511·sin(π(k+0.5)/2048)) for k = 0..1023. Phase bits 11:10 select the quadrant and bits 9:0 form the index i, giving 0:+T[i], 1:+T[1023−i], 2:−T[i], 3:−T[1023−i], as a two's-complement 10-bit value.
- R6: While `pwr_dn_i` is high, the phase register holds its value and the sample loaded at each edge is 0. The offset register still loads `ofs_i`.
- R7: A new tuning word is added from the first edge at which it is present, with no jump in phase. For example, after 4 edges of 0x01000000 and one edge of 0x02000000, the phase address is 0x060.
- R8: A synchronous active-high reset clears the phase register, the offset register and `sample_o` to zero.
- R9: The tuning word 0x80000000 (half the clock rate) makes `square_o` toggle on every edge, starting high after the first edge from reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ftw_i | input | 32 | Frequency tuning word |
| ofs_i | input | 5 | Phase offset, binary-weighted from 180° (bit 4) to 11.25° (bit 0) |
| pwr_dn_i | input | 1 | Power-down: hold phase, zero the sample |
| phase_o | output | 12 | Offset-adjusted truncated phase address |
| sample_o | output | 10 | Signed sine sample, registered |
| square_o | output | 1 | Square wave, top bit of the phase address |

## Verification
On every cycle the assertions check the accumulate step and its wrap, the hold under power-down, the zero sample under power-down, and that a zero tuning word leaves the phase register still whatever the offset does. They also check that the sample sign follows the upper half of the phase circle, and the reset values. Some behaviours only the bench scenarios can show. These are the exact table values after quadrant folding, the binary weight of each offset bit, and the return to the undisturbed trajectory once an offset is removed. The scenarios also cover continuity when the tuning word changes and the alternating square output at the half-clock word.

// File: rtl/dds_nco_pkg.sv
package dds_nco_pkg;

    localparam int ACC_W_DEF  = 32;
    localparam int OFS_W_DEF  = 5;
    localparam int PA_W_DEF   = 12;
    localparam int SMP_W_DEF  = 10;

    localparam real PI_R = 3.14159265358979323846;

    typedef enum logic [1:0] {
        Q_RISE     = 2'b00,
        Q_FALL     = 2'b01,
        Q_NEG_FALL = 2'b10,
        Q_NEG_RISE = 2'b11
    } quad_e;

    // Magnitude of entry k in a quarter-wave table of qdepth entries,
    // scaled to amp and sampled at the centre of each step.
    function automatic int quarter_mag(input int k, input int qdepth, input int amp);
        real ang;
        ang = PI_R * (real'(k) + 0.5) / (2.0 * real'(qdepth));
        return $rtoi(real'(amp) * $sin(ang) + 0.5);
    endfunction

endpackage

// File: rtl/dds_nco_phase_acc.sv
module dds_nco_phase_acc
    import dds_nco_pkg::*;
#(
    parameter int ACC_W = ACC_W_DEF,
    parameter int OFS_W = OFS_W_DEF,
    parameter int PA_W  = PA_W_DEF
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [ACC_W-1:0] ftw_i,
    input  logic [OFS_W-1:0] ofs_i,
    input  logic             pwr_dn_i,
    output logic [PA_W-1:0]  phase_o
);
    localparam int PAD_W = PA_W - OFS_W;

    logic [ACC_W-1:0] acc_q;
    logic [OFS_W-1:0] ofs_q;
    logic [PA_W-1:0]  acc_top;
    logic [PA_W-1:0]  ofs_aligned;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            acc_q <= '0;
            ofs_q <= '0;
        end else begin
            ofs_q <= ofs_i;
            if (!pwr_dn_i) begin
                acc_q <= acc_q + ftw_i;
            end
        end
    end

    // Offset carries no low bits, so only the truncated slice needs adding.
    always_comb begin
        acc_top     = acc_q[ACC_W-1 -: PA_W];
        ofs_aligned = {ofs_q, {PAD_W{1'b0}}};
        phase_o     = acc_top + ofs_aligned;
    end

    // R1
    acc_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !pwr_dn_i |=> acc_q == $past(acc_q + ftw_i));

    // R6
    pd_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        pwr_dn_i |=> $stable(acc_q));

    // R3
    ofs_isolated_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (ftw_i == '0) |=> $stable(acc_q));

    // R8
    acc_reset_chk: assert property (@(posedge clk_i)
        rst_i |=> (acc_q == '0) && (ofs_q == '0));

endmodule

// File: rtl/dds_nco_quarter_rom.sv
module dds_nco_quarter_rom
    import dds_nco_pkg::*;
#(
    parameter int QA_W  = PA_W_DEF - 2,
    parameter int MAG_W = SMP_W_DEF - 1
) (
    input  logic [QA_W-1:0]  idx_i,
    output logic [MAG_W-1:0] mag_o
);
    localparam int QDEPTH = 1 << QA_W;
    localparam int AMP    = (1 << MAG_W) - 1;

    logic [MAG_W-1:0] table_q [QDEPTH];

    initial begin
        for (int k = 0; k < QDEPTH; k++) begin
            table_q[k] = MAG_W'(quarter_mag(k, QDEPTH, AMP));
        end
    end

    assign mag_o = table_q[idx_i];

endmodule

// File: rtl/dds_nco_sine_fold.sv
module dds_nco_sine_fold
    import dds_nco_pkg::*;
#(
    parameter int PA_W  = PA_W_DEF,
    parameter int SMP_W = SMP_W_DEF
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    pwr_dn_i,
    input  logic [PA_W-1:0]         phase_i,
    output logic signed [SMP_W-1:0] sample_o
);
    localparam int QA_W  = PA_W - 2;
    localparam int MAG_W = SMP_W - 1;

    quad_e                    quad;
    logic [QA_W-1:0]          idx_raw;
    logic [QA_W-1:0]          idx_rom;
    logic [MAG_W-1:0]         mag;
    logic signed [SMP_W-1:0]  mag_s;
    logic signed [SMP_W-1:0]  folded;
    logic signed [SMP_W-1:0]  sample_d;

    assign quad    = quad_e'(phase_i[PA_W-1 -: 2]);
    assign idx_raw = phase_i[QA_W-1:0];

    always_comb begin
        unique case (quad)
            Q_RISE, Q_NEG_FALL: idx_rom = idx_raw;
            Q_FALL, Q_NEG_RISE: idx_rom = ~idx_raw;
            default:            idx_rom = idx_raw;
        endcase
    end

    dds_nco_quarter_rom #(
        .QA_W  (QA_W),
        .MAG_W (MAG_W)
    ) u_rom (
        .idx_i (idx_rom),
        .mag_o (mag)
    );

    always_comb begin
        mag_s  = $signed({1'b0, mag});
        folded = phase_i[PA_W-1] ? -mag_s : mag_s;
        sample_d = pwr_dn_i ? '0 : folded;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sample_o <= '0;
        end else begin
            sample_o <= sample_d;
        end
    end

    // R6
    pd_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        pwr_dn_i |=> sample_o == '0);

    // R5
    lower_half_sign_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!pwr_dn_i && phase_i[PA_W-1]) |=> sample_o <= 0);

    // R5
    upper_half_sign_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!pwr_dn_i && !phase_i[PA_W-1]) |=> sample_o >= 0);

    // R8
    sample_reset_chk: assert property (@(posedge clk_i)
        rst_i |=> sample_o == '0);

endmodule

// File: rtl/dds_nco_core.sv
module dds_nco_core
    import dds_nco_pkg::*;
#(
    parameter int ACC_W = ACC_W_DEF,
    parameter int OFS_W = OFS_W_DEF,
    parameter int PA_W  = PA_W_DEF,
    parameter int SMP_W = SMP_W_DEF
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic [ACC_W-1:0]        ftw_i,
    input  logic [OFS_W-1:0]        ofs_i,
    input  logic                    pwr_dn_i,
    output logic [PA_W-1:0]         phase_o,
    output logic signed [SMP_W-1:0] sample_o,
    output logic                    square_o
);
    logic [PA_W-1:0] phase_w;

    dds_nco_phase_acc #(
        .ACC_W (ACC_W),
        .OFS_W (OFS_W),
        .PA_W  (PA_W)
    ) u_acc (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .ftw_i    (ftw_i),
        .ofs_i    (ofs_i),
        .pwr_dn_i (pwr_dn_i),
        .phase_o  (phase_w)
    );

    dds_nco_sine_fold #(
        .PA_W  (PA_W),
        .SMP_W (SMP_W)
    ) u_fold (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .pwr_dn_i (pwr_dn_i),
        .phase_i  (phase_w),
        .sample_o (sample_o)
    );

    assign phase_o  = phase_w;
    assign square_o = phase_w[PA_W-1];

    // R9
    nyquist_toggle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!pwr_dn_i && ftw_i == {1'b1, {(ACC_W-1){1'b0}}} && $stable(ofs_i))
        |=> square_o != $past(square_o));

endmodule

// File: tb/dds_nco_core_bench.sv
`timescale 1ns/1ps
module dds_nco_core_bench;

    typedef struct packed {
        logic [31:0] ftw;
        logic [4:0]  ofs;
        logic [15:0] ncyc;
        logic [11:0] exp_phase;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0010_0000, 5'b00000, 16'd5,   12'h005},
        '{32'h8000_0000, 5'b00000, 16'd3,   12'h800},
        '{32'h4000_0000, 5'b10000, 16'd1,   12'hC00},
        '{32'h0000_0000, 5'b00001, 16'd2,   12'h080},
        '{32'hFFFF_FFFF, 5'b00000, 16'd4,   12'hFFF},
        '{32'h6000_0000, 5'b11111, 16'd3,   12'h180},
        '{32'h0000_1000, 5'b00000, 16'd256, 12'h001}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [31:0]       ftw = '0;
    logic [4:0]        ofs = '0;
    logic              pd  = 1'b0;
    logic [11:0]       phase;
    logic signed [9:0] sample;
    logic              square;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [31:0]       m_acc  = '0;
    logic [4:0]        m_ofs  = '0;
    logic signed [9:0] m_samp = '0;

    always #5 clk = ~clk;

    dds_nco_core u_dds_nco_core (
        .clk_i    (clk),
        .rst_i    (rst),
        .ftw_i    (ftw),
        .ofs_i    (ofs),
        .pwr_dn_i (pd),
        .phase_o  (phase),
        .sample_o (sample),
        .square_o (square)
    );

    function automatic int tbl(input int k);
        return $rtoi(511.0 * $sin(3.14159265358979323846 * (real'(k) + 0.5) / 2048.0) + 0.5);
    endfunction

    function automatic logic signed [9:0] exp_sine(input logic [11:0] p);
        int i;
        int v;
        i = int'(p[9:0]);
        case (p[11:10])
            2'd0: v =  tbl(i);
            2'd1: v =  tbl(1023 - i);
            2'd2: v = -tbl(i);
            default: v = -tbl(1023 - i);
        endcase
        return 10'(v);
    endfunction

    function automatic logic [11:0] m_phase();
        return m_acc[31:20] + {m_ofs, 7'b0};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        if (rst) begin
            m_acc = '0; m_ofs = '0; m_samp = '0;
        end else begin
            m_samp = pd ? 10'sd0 : exp_sine(m_phase());
            if (!pd) m_acc = m_acc + ftw;
            m_ofs = ofs;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic check_model(input string req);
        check({req, " phase"},  int'(phase), int'(m_phase()));
        check({req, " sample"}, int'(sample), int'(m_samp));
        check({req, " square"}, int'(square), int'(m_phase() >> 11));
    endtask

    task automatic do_reset();
        rst = 1'b1; ftw = '0; ofs = '0; pd = 1'b0;
        tick();
        tick();
        rst = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R8 reset state
        do_reset();
        check("R8 phase", int'(phase), 0);
        check("R8 sample", int'(sample), 0);
        check("R8 square", int'(square), 0);

        // R1 R2 R4 R5 vector table
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            ftw = VECS[v].ftw;
            ofs = VECS[v].ofs;
            for (int c = 0; c < int'(VECS[v].ncyc); c++) begin
                tick();
                check_model("R5 R1 table");
            end
            check("R2 table phase", int'(phase), int'(VECS[v].exp_phase));
            check("R4 table square", int'(square), int'(VECS[v].exp_phase[11]));
        end

        // R7 tuning word change is phase continuous
        do_reset();
        ftw = 32'h0100_0000;
        repeat (4) tick();
        ftw = 32'h0200_0000;
        tick();
        check("R7 phase", int'(phase), 12'h060);

        // R3 offset leaves accumulator untouched
        do_reset();
        ftw = 32'h0010_0000;
        repeat (3) tick();
        ofs = 5'b00100;
        repeat (2) tick();
        check("R3 offset phase", int'(phase), 12'h205);
        ofs = 5'b00000;
        tick();
        check("R3 restored phase", int'(phase), 12'h006);

        // R6 power-down hold and zero sample
        do_reset();
        ftw = 32'h0010_0000;
        repeat (2) tick();
        pd = 1'b1;
        tick();
        check("R6 sample zero", int'(sample), 0);
        check("R6 phase held", int'(phase), 12'h002);
        repeat (3) tick();
        check("R6 phase still held", int'(phase), 12'h002);
        ofs = 5'b10000;
        tick();
        check("R6 offset loads", int'(phase), 12'h802);
        check("R6 sample still zero", int'(sample), 0);
        ofs = 5'b00000;
        pd = 1'b0;
        tick();
        check_model("R6 resume");
        check("R6 resumed phase", int'(phase), 12'h003);

        // R5 known table points
        do_reset();
        ofs = 5'b01000;
        repeat (2) tick();
        check("R5 peak", int'(sample), 511);
        ofs = 5'b11000;
        repeat (2) tick();
        check("R5 trough", int'(sample), -511);
        ofs = 5'b10000;
        repeat (2) tick();
        check("R5 half-turn", int'(sample), 0);

        // R9 half-clock word toggles square
        do_reset();
        ftw = 32'h8000_0000;
        for (int c = 1; c <= 6; c++) begin
            tick();
            check("R9 square", int'(square), c % 2);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule